// File: doc/BRIEF.md
# Bus Device Enumeration Sequencer

This block is the master-side controller that discovers the 64-bit identity codes of the devices sharing a single-wire open-drain bus. Each start request runs one search pass. The pass resets the bus, confirms that at least one device answered, and sends the search command. It then walks the 64 code positions from the least significant bit. At each position it reads the wired-AND of the participating devices' bit, reads the wired-AND of the complement, and writes back the branch it chooses. Devices whose bit differs from the written branch drop out of the pass. At the end, the code of exactly one device is left.

Between passes the block keeps the position of the last 0-branch taken at a collision, together with the code of the previous pass. Repeating start therefore lists every device, one per pass, in ascending order of bit-reversed code. The block reports when the device just returned was the final one. It also checks the trailing CRC byte of every code it returns.

The bus side is an abstract slot engine that performs reset-with-presence, write-bit and read-bit operations and ends each one with a done pulse. The result side is a valid/ready port. A result stays on the port until it is taken, and no new pass can begin while a result waits, so a slow consumer only stalls the enumeration.

Top module: `rom_search_master`

## Requirements
- R1: A pass begins with a reset operation (op_kind 0). If op_rdata is 1 when that operation completes, meaning a presence was seen, the block sends 0xF0 as eight write operations (op_kind 1), least significant bit first, so the written bits are 0,0,0,0,1,1,1,1.
- R2: If op_rdata is 0 when the reset completes, the result has status EMPTY (1) and code 0, and no write operation is issued.
- R3: For each of the 64 positions, from bit 0 upward, the block issues a read (op_kind 2) for the true bit, a read for the complement bit, and then a write of the chosen bit. When the two reads differ, the written bit equals the true read.
- R4: When both reads are 0 at 1-based position p, and L is the 1-based collision position recorded after the previous pass (0 means none), the chosen bit is the previous pass's bit if p < L, 1 if p = L, and 0 if p > L. The largest position where 0 was chosen at a collision becomes the new L at the end of the pass. Repeated passes return every device once, in ascending order of bit-reversed code.
- R5: When both reads are 1, the pass stops at once with status NODEV (2) and code 0, without writing a bit for that position, and the collision state is cleared.
- R6: res_last is 1 when a pass records no 0-choice at a collision. The next start then begins a fresh enumeration from the first device.
- R7: The status is OK (0) when the CRC-8 of the code is valid, and CRCBAD (3), with the code still reported, when it is not. The CRC uses polynomial x^8+x^5+x^4+1, bit-serial, LSB first, initial value 0, over bits 0..55, and must equal bits 63..56.
- R8: res_valid stays high, with code, status and last held stable, until res_ready is high. No slot operation is issued while a result waits, and start is ignored unless the block is idle.
- R9: After reset, op_valid and res_valid are 0.
- R10: Once op_valid is raised, op_valid, op_kind and op_wbit hold steady until op_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one search pass (taken only when idle) |
| op_valid | output | 1 | Slot operation requested |
| op_kind | output | 2 | 0 reset/presence, 1 write bit, 2 read bit |
| op_wbit | output | 1 | Bit to write for a write operation |
| op_done | input | 1 | One-cycle pulse: requested operation finished |
| op_rdata | input | 1 | Presence (reset) or sampled bit (read), valid with op_done |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_code | output | 64 | Device code found (bit 0 first on the bus) |
| res_status | output | 2 | 0 OK, 1 EMPTY, 2 NODEV, 3 CRCBAD |
| res_last | output | 1 | No further devices remain after this one |

## Verification
The hardest path to reach is the rule that replays the previous pass's bit below the recorded collision. It only shows up on a third or later pass over a tree with nested collisions. The stimulus is a behavioural model of four devices whose codes share prefixes and diverge at two depths, and the enumeration order is checked against a bit-reversed sort. The dead-bus abort cannot occur with real devices, so the model gets a switch that forces every read high.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } slot_op_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_EMPTY  = 2'd1,
    RES_NODEV  = 2'd2,
    RES_CRCBAD = 2'd3
  } res_stat_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RESET,
    SQ_CMD,
    SQ_RDT,
    SQ_RDC,
    SQ_WR,
    SQ_CHK,
    SQ_OUT
  } seq_state_e;
endpackage

// File: rtl/rsm_crc_serial.sv
module rsm_crc_serial #(
  parameter int          CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  logic             fb;
  logic [CRC_W-1:0] crc_d;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_d = (crc_q >> 1) ^ (fb ? POLY_REFL : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_d;
  end

  // R7
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc_q));
endmodule

// File: rtl/rsm_branch.sv
module rsm_branch #(
  parameter int POS_W = 7
) (
  input  logic             t_bit,
  input  logic             c_bit,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] last_disc,
  input  logic             prev_bit,
  output logic             dir,
  output logic             take_zero,
  output logic             dead
);
  always_comb begin
    dead      = t_bit & c_bit;
    take_zero = 1'b0;
    dir       = 1'b0;
    if (t_bit != c_bit) begin
      dir = t_bit;
    end else if (!t_bit) begin
      if (pos < last_disc)       dir = prev_bit;
      else if (pos == last_disc) dir = 1'b1;
      else                       dir = 1'b0;
      take_zero = ~dir;
    end
  end
endmodule

// File: rtl/rom_search_master.sv
module rom_search_master
  import rsm_pkg::*;
#(
  parameter int          CODE_W   = 64,
  parameter int          CRC_W    = 8,
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CMD_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic              op_wbit,
  input  logic              op_done,
  input  logic              op_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CODE_W-1:0] res_code,
  output logic [1:0]        res_status,
  output logic              res_last
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam int POS_W = IDX_W + 1;
  localparam int CNT_W = $clog2(CMD_W);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] rom_q;
  logic [POS_W-1:0]  last_disc, new_disc, pos;
  logic              t_q, last_q;
  res_stat_e         stat_q;

  logic              dir, take_zero, dead;
  logic              crc_clr, crc_en;
  logic [CRC_W-1:0]  crc_q;

  assign pos = POS_W'(idx) + POS_W'(1);

  rsm_branch #(.POS_W(POS_W)) branch_i (
    .t_bit     (t_q),
    .c_bit     (op_rdata),
    .pos       (pos),
    .last_disc (last_disc),
    .prev_bit  (rom_q[idx]),
    .dir       (dir),
    .take_zero (take_zero),
    .dead      (dead)
  );

  assign crc_clr = (state == SQ_IDLE) && start;
  assign crc_en  = (state == SQ_WR) && op_done;

  rsm_crc_serial #(.CRC_W(CRC_W)) crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (rom_q[idx]),
    .crc_q (crc_q)
  );

  always_comb begin
    op_valid = 1'b0;
    op_kind  = OP_RESET;
    op_wbit  = 1'b0;
    unique case (state)
      SQ_RESET: begin op_valid = 1'b1; op_kind = OP_RESET; end
      SQ_CMD:   begin op_valid = 1'b1; op_kind = OP_WRITE; op_wbit = CMD_CODE[cnt]; end
      SQ_RDT,
      SQ_RDC:   begin op_valid = 1'b1; op_kind = OP_READ; end
      SQ_WR:    begin op_valid = 1'b1; op_kind = OP_WRITE; op_wbit = rom_q[idx]; end
      default:  ;
    endcase
  end

  assign res_valid  = (state == SQ_OUT);
  assign res_code   = rom_q;
  assign res_status = stat_q;
  assign res_last   = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      cnt       <= '0;
      rom_q     <= '0;
      last_disc <= '0;
      new_disc  <= '0;
      t_q       <= 1'b0;
      last_q    <= 1'b0;
      stat_q    <= RES_OK;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state    <= SQ_RESET;
          idx      <= '0;
          cnt      <= '0;
          new_disc <= '0;
        end
        SQ_RESET: if (op_done) begin
          if (op_rdata) state <= SQ_CMD;
          else begin
            stat_q    <= RES_EMPTY;
            rom_q     <= '0;
            last_disc <= '0;
            last_q    <= 1'b0;
            state     <= SQ_OUT;
          end
        end
        SQ_CMD: if (op_done) begin
          if (cnt == CNT_W'(CMD_W - 1)) state <= SQ_RDT;
          else cnt <= cnt + 1'b1;
        end
        SQ_RDT: if (op_done) begin
          t_q   <= op_rdata;
          state <= SQ_RDC;
        end
        SQ_RDC: if (op_done) begin
          if (dead) begin
            stat_q    <= RES_NODEV;
            rom_q     <= '0;
            last_disc <= '0;
            last_q    <= 1'b0;
            state     <= SQ_OUT;
          end else begin
            rom_q[idx] <= dir;
            if (take_zero) new_disc <= pos;
            state <= SQ_WR;
          end
        end
        SQ_WR: if (op_done) begin
          if (idx == IDX_W'(CODE_W - 1)) begin
            last_disc <= new_disc;
            last_q    <= (new_disc == '0);
            state     <= SQ_CHK;
          end else begin
            idx   <= idx + 1'b1;
            state <= SQ_RDT;
          end
        end
        SQ_CHK: begin
          stat_q <= (crc_q == '0) ? RES_OK : RES_CRCBAD;
          state  <= SQ_OUT;
        end
        SQ_OUT: if (res_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) &&
      $stable(res_status) && $stable(res_last)));

  // R8
  op_res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !op_valid);

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_kind) && $stable(op_wbit)));

  // R5
  dead_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RDC && op_done && t_q && op_rdata) |=>
      (res_valid && res_status == RES_NODEV));

  // R2
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RESET && op_done && !op_rdata) |=>
      (res_valid && res_status == RES_EMPTY && res_code == '0));
endmodule

// File: tb/rom_search_master_tb_top.sv
`timescale 1ns/1ps
module rom_search_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        res_ready = 1'b0;
  logic        op_done = 1'b0;
  logic        op_rdata = 1'b0;
  logic        op_valid, op_wbit, res_valid, res_last;
  logic [1:0]  op_kind, res_status;
  logic [63:0] res_code;

  always #2.5 clk = ~clk;

  rom_search_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_valid(op_valid), .op_kind(op_kind), .op_wbit(op_wbit),
    .op_done(op_done), .op_rdata(op_rdata),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_status(res_status), .res_last(res_last)
  );

  int total = 0;
  int bad = 0;

  // device model configuration
  logic [63:0] dev_code [4];
  int          ndev = 0;
  bit          force_dead = 0;

  // device model state
  bit          act [4];
  int          m_cnt = 0;
  int          bpos = 0;
  int          wcount = 0;
  int          bit_wr = 0;
  int          hold_err = 0;
  bit          rphase = 0;
  logic [7:0]  cmd_rx = '0;
  logic [1:0]  cap_kind = '0;
  logic        cap_wbit = 1'b0;

  always @(negedge clk) begin
    if (op_done) begin
      op_done = 1'b0;
      m_cnt = 0;
    end else if (op_valid) begin
      m_cnt++;
      if (m_cnt == 1) begin
        cap_kind = op_kind;
        cap_wbit = op_wbit;
      end else if (op_kind != cap_kind || op_wbit != cap_wbit) begin
        hold_err++;
      end
      if (m_cnt == 3) begin
        case (op_kind)
          2'd0: begin
            op_rdata = (ndev > 0);
            for (int k = 0; k < 4; k++) act[k] = (k < ndev);
            rphase = 0; bpos = 0; wcount = 0; bit_wr = 0; cmd_rx = '0;
          end
          2'd1: begin
            if (wcount < 8) begin
              cmd_rx[wcount] = op_wbit;
              wcount++;
            end else if (bpos < 64) begin
              for (int k = 0; k < 4; k++)
                if (act[k] && dev_code[k][bpos] != op_wbit) act[k] = 0;
              bpos++;
              bit_wr++;
            end
          end
          default: begin
            logic v;
            v = 1'b1;
            if (!force_dead && bpos < 64)
              for (int k = 0; k < 4; k++)
                if (act[k]) v &= rphase ? ~dev_code[k][bpos] : dev_code[k][bpos];
            op_rdata = v;
            rphase = ~rphase;
          end
        endcase
        op_done = 1'b1;
      end
    end
  end

  function automatic logic [7:0] crc56(input logic [55:0] b);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c ^= 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] brev(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[63-i] = x[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act_v, input logic [63:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic run_pass(output logic [63:0] code, output logic [1:0] st,
                          output logic lst);
    int w;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!res_valid && w < 5000) begin @(negedge clk); w++; end
    check(res_valid, "watchdog R8", {63'd0, res_valid}, 64'd1);
    code = res_code; st = res_status; lst = res_last;
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
  endtask

  // stimulus table: device counts and 56-bit code bodies
  localparam int NV = 3;
  localparam int COUNTS [NV] = '{1, 2, 4};
  localparam logic [55:0] BODIES [NV][4] = '{
    '{56'h00A1B2C3D4E501, 56'h0, 56'h0, 56'h0},
    '{56'h00000000000101, 56'h00000000000201, 56'h0, 56'h0},
    '{56'h00000000000128, 56'h00000000000328, 56'h00000000000528, 56'h00000000000728}
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] code, first_code;
    logic [1:0]  st;
    logic        lst;
    bit          found [4];

    repeat (3) @(negedge clk);
    // R9 reset state
    check(op_valid == 1'b0, "R9 op_valid", {63'd0, op_valid}, 64'd0);
    check(res_valid == 1'b0, "R9 res_valid", {63'd0, res_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R3 R4 R6 R7
    for (int e = 0; e < NV; e++) begin
      ndev = COUNTS[e];
      for (int k = 0; k < 4; k++) begin
        dev_code[k] = {crc56(BODIES[e][k]), BODIES[e][k]};
        found[k] = 0;
      end
      for (int p = 0; p < COUNTS[e]; p++) begin
        int best;
        best = -1;
        for (int k = 0; k < COUNTS[e]; k++)
          if (!found[k] && (best < 0 || brev(dev_code[k]) < brev(dev_code[best])))
            best = k;
        found[best] = 1;
        run_pass(code, st, lst);
        check(cmd_rx == 8'hF0, "R1 command", {56'd0, cmd_rx}, 64'hF0);
        check(bit_wr == 64, "R3 bit writes", 64'(bit_wr), 64'd64);
        check(code == dev_code[best], "R4 enumeration order", code, dev_code[best]);
        check(st == 2'd0, "R7 status ok", {62'd0, st}, 64'd0);
        check(lst == (p == COUNTS[e] - 1), "R6 last flag", {63'd0, lst},
              {63'd0, (p == COUNTS[e] - 1)});
      end
    end

    // R6 fresh enumeration after the last device
    first_code = dev_code[0];
    run_pass(code, st, lst);
    check(code == first_code, "R6 fresh restart", code, first_code);
    check(lst == 1'b0, "R6 not last on restart", {63'd0, lst}, 64'd0);

    // R8 back-pressure: result held, start ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!res_valid) @(negedge clk);
    code = res_code;
    start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(res_valid && res_code == code, "R8 result held", res_code, code);
      check(op_valid == 1'b0, "R8 no slot op while waiting", {63'd0, op_valid}, 64'd0);
    end
    start = 1'b0;
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && op_valid == 1'b0, "R8 idle after accept",
          {62'd0, res_valid, op_valid}, 64'd0);

    // R7 bad CRC
    ndev = 1;
    dev_code[0] = {~crc56(56'h00123456789A10), 56'h00123456789A10};
    run_pass(code, st, lst);
    check(st == 2'd3, "R7 crc bad status", {62'd0, st}, 64'd3);
    check(code == dev_code[0], "R7 crc bad code", code, dev_code[0]);

    // R5 dead bus
    force_dead = 1;
    run_pass(code, st, lst);
    check(st == 2'd2, "R5 nodev status", {62'd0, st}, 64'd2);
    check(bit_wr == 0, "R5 no bit write", 64'(bit_wr), 64'd0);
    check(code == 64'd0, "R5 code zero", code, 64'd0);
    force_dead = 0;

    // R2 empty bus
    ndev = 0;
    run_pass(code, st, lst);
    check(st == 2'd1, "R2 empty status", {62'd0, st}, 64'd1);
    check(wcount == 0 && bit_wr == 0, "R2 no writes", 64'(wcount + bit_wr), 64'd0);

    // R10 slot request stability seen by the model
    check(hold_err == 0, "R10 op held until done", 64'(hold_err), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule